// File: doc/BRIEF.md
# Service Request and Serial Poll Responder

This block lets an instrument ask a bus controller for attention and answers the serial poll that follows. The instrument side gives an error event with a numeric error code and a ready event. Each event has its own interrupt enable. An enabled event latches a pending cause and asserts the service request line. The controller then puts the device into serial poll mode and addresses it to talk. While that holds, the block presents a response byte. The byte carries the error code when an error caused the request. It is zero when a ready condition caused it, and also zero (a null byte) when nothing was requested. The controller takes the byte once. That releases the request and clears the pending cause.

The block is built around a three-state machine. `ST_IDLE` means no request is pending. `ST_ERR_PEND` means a request is pending because of an error, with the code held in a register. `ST_RDY_PEND` means a request is pending because of a ready condition. The named transitions are:
- `T_CAPTURE_ERR`: idle to error-pending.
- `T_CAPTURE_RDY`: idle to ready-pending.
- `T_POLL_READ`: either pending state back to idle, when the byte is taken during a poll while talk-addressed.
- `T_HOLD`: every other case keeps the current state.

A separate flag holds the serial poll mode. It is set and cleared by the decoded enable and disable command strobes.

Top module: `srq_poll_responder`

## Requirements
- R1: After reset, `srq` is low, `resp_byte` is 0 and serial poll mode is off.
- R2: In idle, an error event with `err_irq_en` high raises `srq` one cycle later. During a poll, `resp_byte` then equals the error code zero-extended to 8 bits.
- R3: In idle, a ready event with `rdy_irq_en` high raises `srq` one cycle later. During a poll, `resp_byte` then reads 0.
- R4: An event whose own enable is low leaves `srq` low and latches nothing.
- R5: When an enabled error and an enabled ready event arrive in the same cycle, the error is latched.
- R6: While a request is pending, new events of either kind leave `srq` high and leave the latched cause and error code unchanged.
- R7: With no request pending, `resp_byte` during a talk-addressed poll is 0.
- R8: `resp_byte` is 0 whenever serial poll mode is off or `talk_addr` is low.
- R9: A `poll_en_stb` pulse turns serial poll mode on from the next cycle. A `poll_dis_stb` pulse turns it off from the next cycle. When both pulse together, the mode ends up off.
- R10: A `byte_taken` pulse while a request is pending, poll mode is on and `talk_addr` is high lowers `srq` the next cycle and clears the cause. The same pulse with poll mode off or `talk_addr` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 1 | One-cycle error event from the instrument |
| err_code | input | CODE_W | Numeric error code, valid with `err_evt` |
| rdy_evt | input | 1 | One-cycle ready event from the instrument |
| err_irq_en | input | 1 | Interrupt enable for error events |
| rdy_irq_en | input | 1 | Interrupt enable for ready events |
| poll_en_stb | input | 1 | Decoded serial-poll-enable command strobe |
| poll_dis_stb | input | 1 | Decoded serial-poll-disable command strobe |
| talk_addr | input | 1 | Device is currently addressed to talk |
| byte_taken | input | 1 | Controller accepted the presented byte |
| srq | output | 1 | Service request line, active high |
| resp_byte | output | 8 | Serial poll response byte |

## Verification
The bench is built with a 4-bit error code. It sweeps every combination of the two events and the two enables against all sixteen code values. This separates enable gating, the error-over-ready priority, and the code-versus-zero response. Each captured request is then hit with conflicting events carrying an inverted code, which shows whether the latched cause is overwritten. The byte is read with poll mode off, with talk addressing low, and finally with both conditions met, which separates ignored reads from the clearing read. A directed sequence pulses the poll enable and disable strobes alone and together. It watches the response byte to show the mode flag and its disable-wins rule.

// File: rtl/srq_poll_pkg.sv
package srq_poll_pkg;

    localparam int unsigned RESP_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ERR_PEND = 2'd1,
        ST_RDY_PEND = 2'd2
    } srq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_ERR  = 2'd1,
        CAUSE_RDY  = 2'd2
    } srq_cause_e;

endpackage

// File: rtl/srq_poll_mode.sv
module srq_poll_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic en_stb,
    input  logic dis_stb,
    output logic poll_on
);

    // Disable wins over enable when both strobes arrive in one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_on <= 1'b0;
        end else if (dis_stb) begin
            poll_on <= 1'b0;
        end else if (en_stb) begin
            poll_on <= 1'b1;
        end
    end

endmodule

// File: rtl/srq_cause_arb.sv
module srq_cause_arb
    import srq_poll_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic              err_evt,
    input  logic [CODE_W-1:0] err_code,
    input  logic              rdy_evt,
    input  logic              err_en,
    input  logic              rdy_en,
    output srq_cause_e        cause,
    output logic [CODE_W-1:0] cause_code
);

    logic err_ok;
    logic rdy_ok;

    assign err_ok = err_evt && err_en;
    assign rdy_ok = rdy_evt && rdy_en;

    // Error is ranked above ready.
    always_comb begin
        cause      = CAUSE_NONE;
        cause_code = '0;
        if (err_ok) begin
            cause      = CAUSE_ERR;
            cause_code = err_code;
        end else if (rdy_ok) begin
            cause = CAUSE_RDY;
        end
    end

endmodule

// File: rtl/srq_fsm.sv
module srq_fsm
    import srq_poll_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  srq_cause_e        cause,
    input  logic [CODE_W-1:0] cause_code,
    input  logic              poll_on,
    input  logic              talk_addr,
    input  logic              byte_taken,
    output logic              srq,
    output logic [RESP_W-1:0] resp_byte
);

    srq_state_e        state_q;
    srq_state_e        state_d;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;
    logic              polled;
    logic              poll_read;
    logic [RESP_W-1:0] code_ext;

    assign polled    = poll_on && talk_addr;
    assign poll_read = polled && byte_taken;

    // State register and code holding register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Next-state logic: T_CAPTURE_ERR, T_CAPTURE_RDY, T_POLL_READ, T_HOLD.
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cause == CAUSE_ERR) begin
                    state_d = ST_ERR_PEND;
                    code_d  = cause_code;
                end else if (cause == CAUSE_RDY) begin
                    state_d = ST_RDY_PEND;
                    code_d  = '0;
                end
            end
            ST_ERR_PEND, ST_RDY_PEND: begin
                if (poll_read) begin
                    state_d = ST_IDLE;
                    code_d  = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                code_d  = '0;
            end
        endcase
    end

    always_comb begin
        code_ext               = '0;
        code_ext[CODE_W-1:0]   = code_q;
    end

    // Output logic.
    always_comb begin
        srq       = 1'b0;
        resp_byte = '0;
        unique case (state_q)
            ST_IDLE: begin
                srq = 1'b0;
            end
            ST_ERR_PEND: begin
                srq = 1'b1;
                if (polled) resp_byte = code_ext;
            end
            ST_RDY_PEND: begin
                srq = 1'b1;
            end
            default: begin
                srq = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/srq_poll_responder.sv
module srq_poll_responder
    import srq_poll_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_evt,
    input  logic [CODE_W-1:0] err_code,
    input  logic              rdy_evt,
    input  logic              err_irq_en,
    input  logic              rdy_irq_en,
    input  logic              poll_en_stb,
    input  logic              poll_dis_stb,
    input  logic              talk_addr,
    input  logic              byte_taken,
    output logic              srq,
    output logic [7:0]        resp_byte
);

    srq_cause_e        cause;
    logic [CODE_W-1:0] cause_code;
    logic              poll_on;

    generate
        if (CODE_W < 1 || CODE_W > RESP_W) begin : g_bad_width
            initial $error("CODE_W must lie in 1..8");
        end
    endgenerate

    srq_poll_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_stb  (poll_en_stb),
        .dis_stb (poll_dis_stb),
        .poll_on (poll_on)
    );

    srq_cause_arb #(.CODE_W(CODE_W)) u_arb (
        .err_evt    (err_evt),
        .err_code   (err_code),
        .rdy_evt    (rdy_evt),
        .err_en     (err_irq_en),
        .rdy_en     (rdy_irq_en),
        .cause      (cause),
        .cause_code (cause_code)
    );

    srq_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause      (cause),
        .cause_code (cause_code),
        .poll_on    (poll_on),
        .talk_addr  (talk_addr),
        .byte_taken (byte_taken),
        .srq        (srq),
        .resp_byte  (resp_byte)
    );

endmodule

// File: rtl/srq_poll_responder_chk.sv
module srq_poll_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       err_evt,
    input logic       rdy_evt,
    input logic       err_irq_en,
    input logic       rdy_irq_en,
    input logic       poll_en_stb,
    input logic       poll_dis_stb,
    input logic       talk_addr,
    input logic       byte_taken,
    input logic       poll_on,
    input logic       srq,
    input logic [7:0] resp_byte
);

    // R2
    err_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srq && err_evt && err_irq_en) |=> srq);

    // R3
    rdy_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srq && rdy_evt && rdy_irq_en) |=> srq);

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srq && !(err_evt && err_irq_en) && !(rdy_evt && rdy_irq_en)) |=> !srq);

    // R6
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && !byte_taken) |=> (srq && $stable(resp_byte) || !$stable(talk_addr) || !$stable(poll_on)));

    // R7
    idle_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srq |-> (resp_byte == 8'd0));

    // R8
    unpolled_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_on || !talk_addr) |-> (resp_byte == 8'd0));

    // R9
    poll_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_dis_stb |=> !poll_on);

    // R9
    poll_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_en_stb && !poll_dis_stb) |=> poll_on);

    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && byte_taken && poll_on && talk_addr) |=> !srq);

    // R10
    stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && byte_taken && !(poll_on && talk_addr)) |=> srq);

endmodule

bind srq_poll_responder srq_poll_responder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_evt      (err_evt),
    .rdy_evt      (rdy_evt),
    .err_irq_en   (err_irq_en),
    .rdy_irq_en   (rdy_irq_en),
    .poll_en_stb  (poll_en_stb),
    .poll_dis_stb (poll_dis_stb),
    .talk_addr    (talk_addr),
    .byte_taken   (byte_taken),
    .poll_on      (poll_on),
    .srq          (srq),
    .resp_byte    (resp_byte)
);

// File: tb/srq_poll_responder_test.sv
module srq_poll_responder_test;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err_evt = 1'b0;
    logic [CW-1:0] err_code = '0;
    logic          rdy_evt = 1'b0;
    logic          err_irq_en = 1'b0;
    logic          rdy_irq_en = 1'b0;
    logic          poll_en_stb = 1'b0;
    logic          poll_dis_stb = 1'b0;
    logic          talk_addr = 1'b0;
    logic          byte_taken = 1'b0;
    logic          srq;
    logic [7:0]    resp_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    srq_poll_responder #(.CODE_W(CW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_evt      (err_evt),
        .err_code     (err_code),
        .rdy_evt      (rdy_evt),
        .err_irq_en   (err_irq_en),
        .rdy_irq_en   (rdy_irq_en),
        .poll_en_stb  (poll_en_stb),
        .poll_dis_stb (poll_dis_stb),
        .talk_addr    (talk_addr),
        .byte_taken   (byte_taken),
        .srq          (srq),
        .resp_byte    (resp_byte)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        talk_addr = 1'b1;
        #1;
        chk("R1 srq", int'(srq), 0);
        chk("R1 byte", int'(resp_byte), 0);
        // Poll mode off after reset: raise error, byte must stay 0 while talk high.
        err_irq_en = 1'b1; err_evt = 1'b1; err_code = 4'd9;
        tick();
        err_evt = 1'b0;
        chk("R1 poll off", int'(resp_byte), 0);
        // R9 directed: both strobes -> off.
        poll_en_stb = 1'b1; poll_dis_stb = 1'b1;
        tick();
        poll_en_stb = 1'b0; poll_dis_stb = 1'b0;
        chk("R9 both off", int'(resp_byte), 0);
        poll_en_stb = 1'b1;
        tick();
        poll_en_stb = 1'b0;
        chk("R9 enabled", int'(resp_byte), 9);
        poll_dis_stb = 1'b1;
        tick();
        poll_dis_stb = 1'b0;
        chk("R9 disabled", int'(resp_byte), 0);
        chk("R9 srq kept", int'(srq), 1);
        poll_en_stb = 1'b1;
        tick();
        poll_en_stb = 1'b0;
        byte_taken = 1'b1;
        tick();
        byte_taken = 1'b0;
        chk("R10 directed clear", int'(srq), 0);
        // R7: poll active, nothing pending.
        chk("R7 null", int'(resp_byte), 0);
        talk_addr = 1'b0;
        poll_dis_stb = 1'b1;
        tick();
        poll_dis_stb = 1'b0;

        for (int combo = 0; combo < 16; combo++) begin
            for (int code = 0; code < 16; code++) begin
                bit ee, re, een, ren, exp_srq, exp_err;
                int exp_byte;
                ee = combo[0]; re = combo[1]; een = combo[2]; ren = combo[3];
                exp_err  = ee && een;
                exp_srq  = exp_err || (re && ren);
                exp_byte = exp_err ? code : 0;

                err_irq_en = een; rdy_irq_en = ren;
                err_evt = ee; rdy_evt = re; err_code = CW'(code);
                tick();
                err_evt = 1'b0; rdy_evt = 1'b0;
                // R2 R3 R4 R5
                chk("R2_R3_R4_R5 srq", int'(srq), int'(exp_srq));
                chk("R8 unpolled", int'(resp_byte), 0);

                if (exp_srq) begin
                    // R6: conflicting events with inverted code.
                    err_irq_en = 1'b1; rdy_irq_en = 1'b1;
                    err_evt = 1'b1; rdy_evt = 1'b1; err_code = ~CW'(code);
                    tick();
                    err_evt = 1'b0; rdy_evt = 1'b0;
                    chk("R6 srq", int'(srq), 1);
                    // R10 stray read, poll off.
                    byte_taken = 1'b1;
                    tick();
                    byte_taken = 1'b0;
                    chk("R10 stray poll off", int'(srq), 1);
                    poll_en_stb = 1'b1;
                    tick();
                    poll_en_stb = 1'b0;
                    chk("R8 talk low", int'(resp_byte), 0);
                    // R10 stray read, talk low.
                    byte_taken = 1'b1;
                    tick();
                    byte_taken = 1'b0;
                    chk("R10 stray talk low", int'(srq), 1);
                    talk_addr = 1'b1;
                    #1;
                    chk("R2_R3_R5_R6 byte", int'(resp_byte), exp_byte);
                    byte_taken = 1'b1;
                    tick();
                    byte_taken = 1'b0;
                    chk("R10 srq cleared", int'(srq), 0);
                    chk("R10 byte null", int'(resp_byte), 0);
                end else begin
                    poll_en_stb = 1'b1;
                    tick();
                    poll_en_stb = 1'b0;
                    talk_addr = 1'b1;
                    #1;
                    chk("R4_R7 byte", int'(resp_byte), 0);
                end
                talk_addr = 1'b0;
                poll_dis_stb = 1'b1;
                tick();
                poll_dis_stb = 1'b0;
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule